// File: doc/BRIEF.md
# Sequential Multiply-Accumulate FIR Engine

The engine computes one output of an eleven-tap finite impulse response filter each time it is invoked. A caller raises `start` together with a valid 8-bit signed input sample. The engine then pushes the sample into a register-based history chain and walks the taps one at a time. For each tap it fetches the weight from an external single-port RAM, and it folds every product into an 8-bit accumulator through a single shared multiplier.

The weights live outside the block. The engine drives a tap address and a read enable, and it expects the RAM to return the word on the cycle after the address. When the last product has been added, the engine raises `done` and `result_vld` together for one cycle and drops back to idle. A new invocation may be accepted in that same cycle. Arithmetic is two's complement, and every sum wraps modulo 256.

Top module: `fir_seq_engine`

## Requirements
- R1: Reset (active-high, synchronous) clears the sample history and the accumulator and puts the engine into idle. While it is reset and just after, `idle` is 1, `done` and `result_vld` are 0 and `result` is 0.
- R2: An invocation is accepted only in a cycle where `idle`, `start` and `sample_vld` are all 1. If `start` is high without `sample_vld`, nothing happens and `idle` stays 1.
- R3: A `start` that arrives while the engine is busy is ignored. It neither shifts the history nor changes the timing of the run in progress.
- R4: In the 11 consecutive cycles after acceptance, `coef_rd` is 1 and `coef_addr` steps from 10 down to 0, one address per cycle. In every other cycle `coef_rd` is 0.
- R5: The weight for an address is taken from `coef_data` on the cycle that follows the one in which that address was driven.
- R6: On acceptance, history slot 0 takes the new sample and each slot k>0 takes the old value of slot k-1. The result is the sum over k of slot[k] times weight[k], using the updated history. Samples and weights are signed 8-bit values.
- R7: The sum wraps to its low 8 bits (modulo 256). It is never saturated.
- R8: `done` and `result_vld` rise together for exactly one cycle, 13 cycles after the acceptance cycle. During that cycle `result` carries the sum.
- R9: `idle` is 0 from the cycle after acceptance through the cycle before `done`. It is 1 in the `done` cycle, and a start in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Invocation request |
| sample | input | 8 | Signed input sample |
| sample_vld | input | 1 | Qualifies `sample` |
| coef_addr | output | 4 | Tap address to the weight RAM |
| coef_rd | output | 1 | Read enable to the weight RAM |
| coef_data | input | 8 | Signed weight, one cycle after the address |
| result | output | 8 | Signed filter output |
| result_vld | output | 1 | One-cycle strobe qualifying `result` |
| done | output | 1 | One-cycle completion pulse |
| idle | output | 1 | High while no invocation is in progress |

## Verification
The bench holds `start` high through whole runs. A design that let a busy-time start through would shift the history twice and start its address walk over again, and that shows up in later sums. When not being read, the RAM model returns a junk word, so a design that sampled `coef_data` one cycle early or late would build wrong sums. Full-scale positive and negative samples and weights drive the accumulator well past 8 bits, which exposes any saturation or sign-extension mistake. A reset in the middle of a run, followed by an impulse, shows whether stale history or a stale accumulator survived the reset. The bench also tests acceptance in the `done` cycle, which an engine that needed a recovery cycle would miss.

// File: rtl/fir_seq_pkg.sv
package fir_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } fir_state_e;

endpackage

// File: rtl/fir_hist_chain.sv
module fir_hist_chain #(
    parameter int TAPS = 11,
    parameter int DW   = 8,
    parameter int AW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] tap_sel,
    output logic [DW-1:0] tap_val
);

    logic [DW-1:0] hist_d [TAPS];
    logic [DW-1:0] hist_q [TAPS];

    // slot 0 takes the new sample; every other slot takes its lower neighbour
    for (genvar g = 0; g < TAPS; g++) begin : g_slot
        if (g == 0) begin : g_head
            assign hist_d[g] = shift_en ? din : hist_q[g];
        end else begin : g_body
            assign hist_d[g] = shift_en ? hist_q[g-1] : hist_q[g];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < TAPS; i++) begin
            hist_q[i] <= rst ? '0 : hist_d[i];
        end
    end

    always_comb begin
        tap_val = '0;
        for (int i = 0; i < TAPS; i++) begin
            if (tap_sel == AW'(i)) begin
                tap_val = hist_q[i];
            end
        end
    end

endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] acc
);

    logic signed [2*DW-1:0] prod;
    logic        [DW-1:0]   acc_d;
    logic        [DW-1:0]   acc_q;

    // the one multiplier shared by every tap
    always_comb begin
        prod  = $signed(op_a) * $signed(op_b);
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (en) begin
            acc_d = acc_q + prod[DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/fir_seq_ctrl.sv
module fir_seq_ctrl
    import fir_seq_pkg::*;
#(
    parameter int TAPS = 11,
    parameter int AW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          in_vld,
    output logic          idle,
    output logic          accept,
    output logic          coef_rd,
    output logic [AW-1:0] coef_addr,
    output logic          mac_en,
    output logic [AW-1:0] tap_sel,
    output logic          done
);

    localparam logic [AW-1:0] LAST_TAP = AW'(TAPS - 1);

    typedef struct packed {
        fir_state_e    st;
        logic [AW-1:0] addr;
        logic          pend;
        logic [AW-1:0] ptap;
        logic          done;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.pend = 1'b0;
        ctl_d.done = 1'b0;
        accept     = (ctl_q.st == ST_IDLE) && start && in_vld;
        case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.st   = ST_ISSUE;
                    ctl_d.addr = LAST_TAP;
                end
            end
            ST_ISSUE: begin
                ctl_d.pend = 1'b1;
                ctl_d.ptap = ctl_q.addr;
                if (ctl_q.addr == '0) begin
                    ctl_d.st = ST_DRAIN;
                end else begin
                    ctl_d.addr = ctl_q.addr - 1'b1;
                end
            end
            ST_DRAIN: begin
                ctl_d.st   = ST_IDLE;
                ctl_d.done = 1'b1;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.addr <= '0;
            ctl_q.pend <= 1'b0;
            ctl_q.ptap <= '0;
            ctl_q.done <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign idle      = (ctl_q.st == ST_IDLE);
    assign coef_rd   = (ctl_q.st == ST_ISSUE);
    assign coef_addr = ctl_q.addr;
    assign mac_en    = ctl_q.pend;
    assign tap_sel   = ctl_q.ptap;
    assign done      = ctl_q.done;

    // R2
    accept_starts_walk_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && start && in_vld) |=> (coef_rd && coef_addr == LAST_TAP));

    // R4
    addr_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(coef_rd) |-> (coef_addr == LAST_TAP));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (coef_rd && $past(coef_rd)) |-> (coef_addr == $past(coef_addr) - 1'b1));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> idle);

endmodule

// File: rtl/fir_seq_engine.sv
module fir_seq_engine #(
    parameter int TAPS = 11,
    parameter int DW   = 8,
    localparam int AW  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] sample,
    input  logic          sample_vld,
    output logic [AW-1:0] coef_addr,
    output logic          coef_rd,
    input  logic [DW-1:0] coef_data,
    output logic [DW-1:0] result,
    output logic          result_vld,
    output logic          done,
    output logic          idle
);

    logic          accept;
    logic          mac_en;
    logic [AW-1:0] tap_sel;
    logic [DW-1:0] tap_val;
    logic          done_w;

    fir_seq_ctrl #(.TAPS(TAPS), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_vld    (sample_vld),
        .idle      (idle),
        .accept    (accept),
        .coef_rd   (coef_rd),
        .coef_addr (coef_addr),
        .mac_en    (mac_en),
        .tap_sel   (tap_sel),
        .done      (done_w)
    );

    fir_hist_chain #(.TAPS(TAPS), .DW(DW), .AW(AW)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (accept),
        .din      (sample),
        .tap_sel  (tap_sel),
        .tap_val  (tap_val)
    );

    fir_mac_unit #(.DW(DW)) u_mac (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .en   (mac_en),
        .op_a (tap_val),
        .op_b (coef_data),
        .acc  (result)
    );

    assign done       = done_w;
    assign result_vld = done_w;

    // R5
    mac_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        mac_en |-> $past(coef_rd));

endmodule

// File: tb/fir_seq_engine_test.sv
module fir_seq_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int TAPS       = 11;
    localparam int RUN_LEN    = TAPS + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] sample = '0;
    logic       sample_vld = 1'b0;
    logic [3:0] coef_addr;
    logic       coef_rd;
    logic [7:0] coef_data = 8'hA5;
    logic [7:0] result;
    logic       result_vld;
    logic       done;
    logic       idle;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [7:0] wmem [16];

    // reference model state
    int         m_cnt = 0;
    int         m_hist [TAPS];
    logic [7:0] m_pend = '0;
    logic [7:0] m_y = '0;
    logic       m_done = 1'b0;

    fir_seq_engine uut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .sample     (sample),
        .sample_vld (sample_vld),
        .coef_addr  (coef_addr),
        .coef_rd    (coef_rd),
        .coef_data  (coef_data),
        .result     (result),
        .result_vld (result_vld),
        .done       (done),
        .idle       (idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // weight RAM: one-cycle read latency, junk word when not read
    always @(posedge clk) begin
        coef_data <= coef_rd ? wmem[coef_addr] : 8'hA5;
    end

    // behavioural reference, updated at each edge
    always @(posedge clk) begin
        if (rst) begin
            m_cnt  = 0;
            m_done = 1'b0;
            m_y    = '0;
            foreach (m_hist[k]) m_hist[k] = 0;
        end else begin
            m_done = 1'b0;
            if (m_cnt == 0 && start && sample_vld) begin
                int sum;
                for (int k = TAPS-1; k > 0; k--) m_hist[k] = m_hist[k-1];
                m_hist[0] = int'($signed(sample));
                sum = 0;
                for (int k = 0; k < TAPS; k++) sum += m_hist[k] * int'($signed(wmem[k]));
                m_pend = sum[7:0];
                m_cnt  = RUN_LEN;
            end else if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1'b1;
                    m_y    = m_pend;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // cycle-by-cycle comparison, away from the clock edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(1'b0, "watchdog", cycles, 100000);
            finish_run();
        end
        if (!rst) begin
            check(idle == (m_cnt == 0), "R9 idle", int'(idle), int'(m_cnt == 0));
            // R8
            check(done == m_done, "R8 done", int'(done), int'(m_done));
            check(result_vld == m_done, "R8 result_vld", int'(result_vld), int'(m_done));
            // R4
            check(coef_rd == (m_cnt >= 2), "R4 coef_rd", int'(coef_rd), int'(m_cnt >= 2));
            if (m_cnt >= 2)
                check(coef_addr == 4'(m_cnt - 2), "R4 coef_addr", int'(coef_addr), m_cnt - 2);
            if (m_done)
                check(result == m_y, "R5 R6 R7 result", int'(result), int'(m_y));
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic invoke(logic [7:0] s);
        start = 1'b1; sample = s; sample_vld = 1'b1;
        step(1);
        start = 1'b0; sample_vld = 1'b0; sample = 8'h3C;
        step(RUN_LEN + 1);
    endtask

    initial begin
        foreach (wmem[k]) wmem[k] = 8'(k + 1);
        step(3);
        // R1: reset state
        check(idle == 1'b1, "R1 idle", int'(idle), 1);
        check(done == 1'b0 && result_vld == 1'b0, "R1 strobes", int'(done), 0);
        check(result == 8'h00, "R1 result", int'(result), 0);
        rst = 1'b0;
        step(1);

        // impulse response walks the weights out one per invocation (R6)
        invoke(8'h01);
        for (int i = 0; i < TAPS; i++) invoke(8'h00);

        // R2: start without a valid sample is ignored
        start = 1'b1; sample = 8'h7F; sample_vld = 1'b0;
        step(3);
        check(idle == 1'b1, "R2 idle held", int'(idle), 1);
        start = 1'b0;
        step(1);

        // R3 R9: start held high; busy-time starts ignored, back-to-back in done cycle
        start = 1'b1; sample_vld = 1'b1;
        for (int i = 0; i < 3 * (RUN_LEN + 1); i++) begin
            sample = 8'(i * 7 - 20);
            step(1);
        end
        start = 1'b0; sample_vld = 1'b0;
        step(RUN_LEN + 2);

        // R7: full-scale wrap, positive and negative
        foreach (wmem[k]) wmem[k] = 8'h7F;
        for (int i = 0; i < TAPS; i++) invoke(8'h7F);
        foreach (wmem[k]) wmem[k] = 8'h80;
        for (int i = 0; i < 4; i++) invoke(8'h80);
        invoke(8'h7F);

        // mixed-sign weights and samples
        foreach (wmem[k]) wmem[k] = 8'((k * 37) ^ 8'h5B);
        for (int i = 0; i < 8; i++) invoke(8'((i * 53) + 11));

        // R1: reset mid-run clears history and accumulator
        start = 1'b1; sample = 8'h55; sample_vld = 1'b1;
        step(1);
        start = 1'b0; sample_vld = 1'b0;
        step(5);
        rst = 1'b1;
        step(2);
        check(idle == 1'b1 && result == 8'h00, "R1 mid-run reset", int'(result), 0);
        rst = 1'b0;
        step(1);
        invoke(8'h01);
        invoke(8'h00);

        step(3);
        finish_run();
    end

endmodule